// File: doc/BRIEF.md
# SPI Chip-Select Delay Sequencer

This block drives the active-low slave-select lines of a serial peripheral master and decides when the clock-and-shift engine may begin each word. Requests arrive one at a time with a target index. The sequencer lowers the matching select line and waits a setup time programmed for that target. It then pulses a start strobe to the engine and waits for the engine's completion strobe. Once a word completes, the sequencer looks at what is queued next. A request for the same target keeps the line low and waits a per-target inter-word spacing. A request for a different target, or no request at all, releases the line and enforces one shared idle gap before any line can drop again.

Two addressing modes are offered. In variable mode every request carries its own target index. In fixed mode the request's index is ignored and one configured target is used for all traffic. Every delay is a count of system clock cycles. A programmed zero behaves as one cycle. The setup and spacing values are latched when a line is asserted, and the gap value is latched when a line is released, so software may rewrite them during a burst without disturbing it.

Top module: `csel_sequencer`

## Requirements
- R1: There are CS_COUNT (default 4) select outputs, active low. Target index n drives bit n of `cs_n`. At most one bit is low at any time, and the low bit during a transfer is the one for the addressed target.
- R2: After synchronous reset, all `cs_n` bits are high, `xfer_start` is low and `req_ready` is high.
- R3: A request accepted while idle lowers its select line on the next cycle. The line then stays low for exactly max(S,1) cycles before the cycle in which `xfer_start` is high. S is that target's setup field, taken from `setup_dly[n*DLY_W +: DLY_W]`.
- R4: A request for the same target accepted in the cycle where `xfer_done` is high keeps the line low. `xfer_start` then rises after exactly max(B,1) cycles following the done cycle. B is the target's spacing field, taken from `between_dly[n*DLY_W +: DLY_W]`.
- R5: A request for a different target accepted in the done cycle produces exactly 1+max(G,1) cycles with all lines high before the new line falls, where G is `gap_dly`. The new line is then timed by R3.
- R6: If no request is present in the done cycle, the line is released on the next cycle and the block returns to idle with all lines high and `req_ready` high.
- R7: When `mode_fixed` is 1, `req_cs` is ignored and `fixed_cs` selects the target. Successive requests therefore always take the same-target path of R4.
- R8: The setup and spacing values are captured when a line is asserted, and G is captured at release. Writes to these inputs after capture do not change the current burst.
- R9: A delay field of 0 gives the same timing as a field of 1.
- R10: `xfer_start` is a single-cycle pulse, issued exactly once per accepted request. `req_ready` is high only while idle or in a cycle where `xfer_done` is high.
- R11: The asserted select never moves directly from one target to another: at least one all-high cycle lies between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A transfer request is presented |
| req_ready | output | 1 | Request accepted in this cycle when valid |
| req_cs | input | CS_IDX_W | Target index of the request (variable mode) |
| mode_fixed | input | 1 | 1 selects fixed addressing |
| fixed_cs | input | CS_IDX_W | Target index used in fixed mode |
| gap_dly | input | DLY_W | Shared idle gap between different targets, in cycles |
| setup_dly | input | CS_COUNT*DLY_W | Per-target select-to-start delay, target n at bits n*DLY_W upward |
| between_dly | input | CS_COUNT*DLY_W | Per-target spacing between words on one target |
| xfer_start | output | 1 | One-cycle pulse telling the engine to begin a word |
| xfer_done | input | 1 | One-cycle pulse from the engine at the end of a word |
| cs_n | output | CS_COUNT | Active-low select lines |

## Verification
On every cycle, the assertions check the following: at most one line is low, and no line is low in the idle, release or gap phases. A start pulse lasts one cycle and only occurs with a line low. The selected line never jumps between targets without an all-high cycle, and the delay counter decrements by exactly one. The exact lengths of the setup, spacing and gap windows can only be shown by the bench's scenarios, which measure them at the ports against values computed from the programmed fields. The same applies to the choice between the same-target and release paths, the fixed-mode override, and the capture of delay values while software rewrites them mid-burst.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;

    parameter int unsigned CS_COUNT = 4;
    parameter int unsigned DLY_W    = 8;

    localparam int unsigned CS_IDX_W = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1;

    typedef logic [CS_IDX_W-1:0] cs_idx_t;
    typedef logic [DLY_W-1:0]    dly_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CS_GAP,
        ST_CS_SETUP,
        ST_TRANSFER,
        ST_INTER_XFER,
        ST_RELEASE
    } seq_state_e;

    // Burst context captured when a select line goes low.
    typedef struct packed {
        cs_idx_t cs;
        dly_t    between;
    } burst_ctx_t;

    function automatic logic line_held(input seq_state_e s);
        return (s == ST_CS_SETUP) || (s == ST_TRANSFER) || (s == ST_INTER_XFER);
    endfunction

endpackage

// File: rtl/csel_delay_timer.sv
`timescale 1ns/1ps
module csel_delay_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] count_q;

    // A loaded value D gives max(D,1) cycles before expiry.
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= (value == '0) ? '0 : value - W'(1);
        end else if (count_q != '0) begin
            count_q <= count_q - W'(1);
        end
    end

    assign expired = (count_q == '0);

    assert_timer_steps_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(count_q) != '0) |-> (count_q == $past(count_q) - W'(1)));

    assert_zero_as_one_R9: assert property (@(posedge clk) disable iff (rst)
        (load && value == '0) |=> expired);

endmodule

// File: rtl/csel_cfg_pick.sv
`timescale 1ns/1ps
module csel_cfg_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned W  = 8,
    parameter int unsigned IW = 2
) (
    input  logic [N*W-1:0] setup_flat,
    input  logic [N*W-1:0] between_flat,
    input  logic [IW-1:0]  idx,
    output logic [W-1:0]   setup_sel,
    output logic [W-1:0]   between_sel
);
    logic [W-1:0] setup_arr   [N];
    logic [W-1:0] between_arr [N];

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign setup_arr[g]   = setup_flat[g*W +: W];
        assign between_arr[g] = between_flat[g*W +: W];
    end

    assign setup_sel   = setup_arr[idx];
    assign between_sel = between_arr[idx];

endmodule

// File: rtl/csel_cs_drive.sv
`timescale 1ns/1ps
module csel_cs_drive #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  cs_n
);
    for (genvar g = 0; g < N; g++) begin : g_line
        assign cs_n[g] = ~(active && (idx == IW'(g)));
    end

    assert_one_low_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

endmodule

// File: rtl/csel_sequencer.sv
`timescale 1ns/1ps
module csel_sequencer
    import csel_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [CS_IDX_W-1:0]       req_cs,
    input  logic                      mode_fixed,
    input  logic [CS_IDX_W-1:0]       fixed_cs,
    input  logic [DLY_W-1:0]          gap_dly,
    input  logic [CS_COUNT*DLY_W-1:0] setup_dly,
    input  logic [CS_COUNT*DLY_W-1:0] between_dly,
    output logic                      xfer_start,
    input  logic                      xfer_done,
    output logic [CS_COUNT-1:0]       cs_n
);
    localparam logic [CS_COUNT-1:0] ALL_HIGH = '1;

    seq_state_e state_q, state_d;
    burst_ctx_t ctx_q, ctx_d;
    cs_idx_t    pend_cs_q, pend_cs_d;
    logic       pend_q, pend_d;
    logic       start_q, start_d;

    cs_idx_t want_cs;
    cs_idx_t pick_idx;
    dly_t    setup_sel;
    dly_t    between_sel;
    logic    tmr_load;
    dly_t    tmr_value;
    logic    tmr_expired;

    // Fixed mode overrides the index carried by the request.
    assign want_cs  = mode_fixed ? fixed_cs : req_cs;
    assign pick_idx = (state_q == ST_CS_GAP) ? pend_cs_q : want_cs;

    assign req_ready = (state_q == ST_IDLE) || ((state_q == ST_TRANSFER) && xfer_done);

    csel_cfg_pick #(
        .N  (CS_COUNT),
        .W  (DLY_W),
        .IW (CS_IDX_W)
    ) u_pick (
        .setup_flat   (setup_dly),
        .between_flat (between_dly),
        .idx          (pick_idx),
        .setup_sel    (setup_sel),
        .between_sel  (between_sel)
    );

    csel_delay_timer #(
        .W (DLY_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .value   (tmr_value),
        .expired (tmr_expired)
    );

    always_comb begin
        state_d   = state_q;
        ctx_d     = ctx_q;
        pend_d    = pend_q;
        pend_cs_d = pend_cs_q;
        start_d   = 1'b0;
        tmr_load  = 1'b0;
        tmr_value = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d       = ST_CS_SETUP;
                    tmr_load      = 1'b1;
                    tmr_value     = setup_sel;
                    ctx_d.cs      = want_cs;
                    ctx_d.between = between_sel;
                end
            end
            ST_CS_SETUP: begin
                if (tmr_expired) begin
                    state_d = ST_TRANSFER;
                    start_d = 1'b1;
                end
            end
            ST_TRANSFER: begin
                if (xfer_done) begin
                    if (req_valid && (want_cs == ctx_q.cs)) begin
                        state_d   = ST_INTER_XFER;
                        tmr_load  = 1'b1;
                        tmr_value = ctx_q.between;
                    end else begin
                        state_d   = ST_RELEASE;
                        pend_d    = req_valid;
                        pend_cs_d = want_cs;
                    end
                end
            end
            ST_INTER_XFER: begin
                if (tmr_expired) begin
                    state_d = ST_TRANSFER;
                    start_d = 1'b1;
                end
            end
            ST_RELEASE: begin
                state_d   = ST_CS_GAP;
                tmr_load  = 1'b1;
                tmr_value = gap_dly;
            end
            ST_CS_GAP: begin
                if (tmr_expired) begin
                    if (pend_q) begin
                        state_d       = ST_CS_SETUP;
                        tmr_load      = 1'b1;
                        tmr_value     = setup_sel;
                        ctx_d.cs      = pend_cs_q;
                        ctx_d.between = between_sel;
                        pend_d        = 1'b0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctx_q     <= '0;
            pend_q    <= 1'b0;
            pend_cs_q <= '0;
            start_q   <= 1'b0;
        end else begin
            state_q   <= state_d;
            ctx_q     <= ctx_d;
            pend_q    <= pend_d;
            pend_cs_q <= pend_cs_d;
            start_q   <= start_d;
        end
    end

    assign xfer_start = start_q;

    csel_cs_drive #(
        .N  (CS_COUNT),
        .IW (CS_IDX_W)
    ) u_drive (
        .clk    (clk),
        .rst    (rst),
        .active (line_held(state_q)),
        .idx    (ctx_q.cs),
        .cs_n   (cs_n)
    );

    assert_quiet_phases_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {ST_IDLE, ST_RELEASE, ST_CS_GAP}) |-> (cs_n == ALL_HIGH));

    assert_start_with_line_R3: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> (cs_n != ALL_HIGH));

    assert_start_single_R10: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start);

    assert_ready_gate_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ((cs_n == ALL_HIGH && !xfer_start) || xfer_done));

    assert_release_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRANSFER && xfer_done && !req_valid) |=> (cs_n == ALL_HIGH));

    assert_no_direct_swap_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) != ALL_HIGH && cs_n != ALL_HIGH) |-> (cs_n == $past(cs_n)));

endmodule

// File: tb/test_csel_sequencer.sv
`timescale 1ns/1ps
module test_csel_sequencer;
    import csel_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                      req_valid = 1'b0;
    logic                      req_ready;
    logic [CS_IDX_W-1:0]       req_cs = '0;
    logic                      mode_fixed = 1'b0;
    logic [CS_IDX_W-1:0]       fixed_cs = '0;
    logic [DLY_W-1:0]          gap_cfg = '0;
    logic [DLY_W-1:0]          setup_cfg   [CS_COUNT];
    logic [DLY_W-1:0]          between_cfg [CS_COUNT];
    logic [CS_COUNT*DLY_W-1:0] setup_flat;
    logic [CS_COUNT*DLY_W-1:0] between_flat;
    logic                      xfer_start;
    logic                      xfer_done = 1'b0;
    logic [CS_COUNT-1:0]       cs_n;

    always_comb begin
        for (int i = 0; i < CS_COUNT; i++) begin
            setup_flat[i*DLY_W +: DLY_W]   = setup_cfg[i];
            between_flat[i*DLY_W +: DLY_W] = between_cfg[i];
        end
    end

    csel_sequencer i_csel_sequencer (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_cs      (req_cs),
        .mode_fixed  (mode_fixed),
        .fixed_cs    (fixed_cs),
        .gap_dly     (gap_cfg),
        .setup_dly   (setup_flat),
        .between_dly (between_flat),
        .xfer_start  (xfer_start),
        .xfer_done   (xfer_done),
        .cs_n        (cs_n)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int at_least_one(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int low_index(input logic [CS_COUNT-1:0] v);
        for (int i = 0; i < CS_COUNT; i++) if (!v[i]) return i;
        return -1;
    endfunction

    typedef struct {
        int    cs;
        int    lead;
        int    gap;
        bit    first;
        string req;
    } exp_t;

    exp_t q[$];
    int   prev_eff = -1;
    int   lat_between = 0;

    // Driver: presents one request, predicts its start timing, pushes it.
    task automatic send(input int cs, input string tag);
        exp_t e;
        int   eff;
        bit   chained;
        req_cs    = CS_IDX_W'(cs);
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        chained = xfer_done;
        eff = mode_fixed ? int'(fixed_cs) : cs;
        e.cs = eff;
        if (chained && eff == prev_eff) begin
            e.first = 1'b0;
            e.lead  = at_least_one(lat_between);
            e.gap   = -1;
            e.req   = {"R4 ", tag};
        end else begin
            e.first     = 1'b1;
            e.lead      = at_least_one(setup_cfg[eff]);
            e.gap       = chained ? 1 + at_least_one(gap_cfg) : -1;
            e.req       = chained ? {"R5/R11 ", tag} : {"R3 ", tag};
            lat_between = between_cfg[eff];
        end
        prev_eff = eff;
        q.push_back(e);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // Engine model: completes each word three cycles after its start.
    always begin
        @(negedge clk);
        if (!rst && xfer_start) begin
            repeat (3) @(posedge clk);
            #1 xfer_done = 1'b1;
            @(posedge clk);
            #1 xfer_done = 1'b0;
        end
    end

    // Monitor: measures windows at the ports and compares with the queue.
    int   hi_run = 0;
    int   last_hi = 0;
    int   low_run = 0;
    int   since_done = 0;
    exp_t mon_e;

    always @(negedge clk) begin
        if (rst) begin
            hi_run = 0; low_run = 0; since_done = 0;
        end else begin
            if (cs_n == '1) begin
                hi_run++;
                low_run = 0;
            end else begin
                if (hi_run != 0) last_hi = hi_run;
                hi_run = 0;
            end
            if (xfer_start) begin
                if (q.size() == 0) begin
                    check("R10 unexpected start", 1, 0);
                end else begin
                    mon_e = q.pop_front();
                    check({"R1 target ", mon_e.req}, low_index(cs_n), mon_e.cs);
                    check({mon_e.req, " lead"}, mon_e.first ? low_run : since_done, mon_e.lead);
                    if (mon_e.gap >= 0) check({mon_e.req, " gap"}, last_hi, mon_e.gap);
                end
            end
            if (cs_n != '1) low_run++;
            if (xfer_done) since_done = 0;
            else since_done++;
        end
    end

    task automatic settle();
        while (q.size() != 0) @(posedge clk);
        repeat (30) @(posedge clk);
        #1;
        @(negedge clk);
        check("R6 lines high when idle", int'(cs_n), (1 << CS_COUNT) - 1);
        check("R6 ready when idle", int'(req_ready), 1);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        setup_cfg[0] = 8'd2; setup_cfg[1] = 8'd3; setup_cfg[2] = 8'd0; setup_cfg[3] = 8'd5;
        between_cfg[0] = 8'd1; between_cfg[1] = 8'd4; between_cfg[2] = 8'd2; between_cfg[3] = 8'd0;
        gap_cfg = 8'd3;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R2 reset lines", int'(cs_n), (1 << CS_COUNT) - 1);
        check("R2 reset start", int'(xfer_start), 0);
        check("R2 reset ready", int'(req_ready), 1);
        @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk);
        #1;

        // Variable addressing with mixed same and different targets.
        send(0, "var");
        send(0, "var");
        send(2, "R9 zero setup");
        send(2, "var");
        send(3, "var");
        send(3, "R9 zero spacing");
        send(1, "var");
        settle();

        // Zero shared gap.
        gap_cfg = 8'd0;
        send(1, "R9 zero gap");
        send(0, "R9 zero gap");
        settle();

        // Rewrite delays in the middle of a burst.
        gap_cfg = 8'd2;
        send(1, "R8 capture");
        between_cfg[1] = 8'd7;
        setup_cfg[1]   = 8'd9;
        send(1, "R8 capture");
        send(1, "R8 capture");
        settle();
        send(1, "R8 new burst");
        send(1, "R8 new burst");
        settle();

        // Fixed addressing ignores the request index.
        mode_fixed = 1'b1;
        fixed_cs   = 2'd2;
        send(0, "R7 fixed");
        send(3, "R7 fixed");
        send(1, "R7 fixed");
        settle();

        check("R10 every request started", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule